// File: doc/BRIEF.md
# Dual Edge-Selectable Interrupt Detector

This block watches two asynchronous input pins: a general interrupt pin and a vertical-sync pin. Each pin goes through a synchronizer and then into a level register. An edge detector follows, with its active polarity set by software. When the active edge is seen, the detector sets a sticky request flag. The flag stays set until software clears it or the interrupt controller acknowledges it.

The edge detector works on the synchronized level folded with the select bit. It does not look at the raw level. So when a select bit is rewritten while its pin is held steady, a request can appear just as if the pin had moved. The two level registers can be read at any time and also serve as a 2-bit general-purpose input port. Request flags are set whether or not the interrupt is enabled, so software may also poll them for edges.

A small register interface gives software access to the block:
- Address 0 is the write-only polarity register.
- Address 1 is the read-only level register.
- Address 2 is the request register, which is cleared by writing 1s.

Each interrupt output is a registered AND of the request flag and its enable.

Top module: `edge_irq_detect`

## Requirements
- R1: After a synchronous reset, both polarity bits are 0 (falling edge), both request flags are 0 and both interrupt outputs are 0. The level register equals the steady pin levels, and no request appears at reset.
- R2: With polarity bit 1 (rising), a low-to-high pin change that is applied before a clock edge sets the request flag on the third clock edge. It is not yet set on the second.
- R3: With polarity bit 0 (falling), a high-to-low pin change sets that source's request flag.
- R4: A pin change in the direction opposite to the selected polarity leaves the request flag clear.
- R5: With the pin held steady, rewriting the polarity bit so that the folded signal goes from inactive to active sets the request flag. This is pin high with the bit going 0 to 1, or pin low with the bit going 1 to 0. The flag is set on the clock edge after the write takes effect.
- R6: Reading address 1 returns the synchronized pin levels (bit 0 general pin, bit 1 vertical-sync pin) three clock edges after a pin change, whatever the enables are.
- R7: While a source's enable is 0, its request flag stays set once set, and its acknowledge input has no effect on it.
- R8: Writing address 0 loads the polarity bits (bit 0 general pin, bit 1 vertical-sync pin, 1 = rising). Writing address 2 clears each request flag whose data bit is 1 and leaves flags with data bit 0 unchanged. Reading address 2 returns the flags in the same bit order. Reading address 0 returns 0.
- R9: With a source enabled, an acknowledge pulse clears its request flag on that clock edge. If an active edge is detected in the same cycle as a clear, the flag stays set.
- R10: Each interrupt output is the registered value of the next request flag ANDed with its enable. It is never high while its request flag is low, and it drops one edge after its enable goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_gen | input | 1 | Asynchronous general interrupt pin |
| pin_vsync | input | 1 | Asynchronous vertical-sync pin |
| irq_en | input | 2 | Interrupt enable per source (bit 0 general, bit 1 vsync) |
| irq_ack | input | 2 | One-cycle acknowledge per source from the interrupt controller |
| reg_addr | input | 2 | Register address: 0 polarity, 1 level, 2 request |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Read data for the addressed register (combinational) |
| irq_out | output | 2 | Registered interrupt requests to the controller |

## Verification
The bench changes a polarity bit while the pin is held steady. A design that detects edges on the raw level would miss the resulting request, and a design that fails to load its history at reset would raise a spurious one. It pulses acknowledge in the exact cycle a select-driven edge is detected, which catches a design where clear beats set. It also pulses acknowledge while the source is disabled and writes 0 bits to the request register, which catches flags that clear when they should not. The three-edge pin-to-flag latency is checked on both sides of the edge, so a missing or extra synchronizer stage shows up. A long random phase compares every interrupt output and register read against a reference model computed by the bench.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_POLARITY = 2'd0,
        REG_LEVEL    = 2'd1,
        REG_REQUEST  = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic level;
        logic req;
        logic irq;
    } src_status_t;

    // Folded signal is high when the level matches the selected active state.
    function automatic logic polarity_fold(input logic lvl, input logic rise_sel);
        return ~(lvl ^ rise_sel);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_synced
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{pin_async}};
        end else begin
            chain_q <= {chain_q[TOP-1:0], pin_async};
        end
    end

    assign pin_synced = chain_q[TOP];

endmodule

// File: rtl/edge_unit.sv
module edge_unit
    import edge_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl_sync,
    input  logic        rise_sel,
    input  logic        en,
    input  logic        ack,
    input  logic        sw_clr,
    output src_status_t status
);
    logic pol_now;
    logic pol_prev;
    logic edge_hit;
    logic clr;
    logic req_nxt;
    logic lvl_q;
    logic req_q;
    logic irq_q;

    assign pol_now  = polarity_fold(lvl_sync, rise_sel);
    assign edge_hit = pol_now & ~pol_prev;
    assign clr      = sw_clr | (ack & en);
    assign req_nxt  = edge_hit | (req_q & ~clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_prev <= polarity_fold(lvl_sync, 1'b0);
            lvl_q    <= lvl_sync;
            req_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            pol_prev <= pol_now;
            lvl_q    <= lvl_sync;
            req_q    <= req_nxt;
            irq_q    <= req_nxt & en;
        end
    end

    assign status = '{level: lvl_q, req: req_q, irq: irq_q};

    AST_STICKY_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (req_q && !en && !sw_clr) |=> req_q); // R7
    AST_REQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> $past(pol_now != pol_prev)); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (edge_hit && clr) |=> req_q); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr && !edge_hit) |=> !req_q); // R8
    AST_IRQ_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> req_q); // R10
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(en)); // R10

endmodule

// File: rtl/edge_reg_if.sv
module edge_reg_if
    import edge_irq_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      levels,
    input  logic [N-1:0]      reqs,
    output logic [N-1:0]      rise_sel,
    output logic [N-1:0]      sw_clr,
    output logic [N-1:0]      rdata
);
    logic [N-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr && addr == REG_POLARITY) begin
            sel_q <= wdata;
        end
    end

    assign rise_sel = sel_q;
    assign sw_clr   = (wr && addr == REG_REQUEST) ? wdata : '0;

    always_comb begin
        case (addr)
            REG_LEVEL:   rdata = levels;
            REG_REQUEST: rdata = reqs;
            default:     rdata = '0;
        endcase
    end

    AST_RESET_POLARITY: assert property (@(posedge clk)
        rst |=> (sel_q == '0)); // R1
    AST_POLARITY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == REG_POLARITY) |=> $stable(sel_q)); // R8

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
    import edge_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_gen,
    input  logic                pin_vsync,
    input  logic [NUM_SRC-1:0]  irq_en,
    input  logic [NUM_SRC-1:0]  irq_ack,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [NUM_SRC-1:0]  reg_wdata,
    output logic [NUM_SRC-1:0]  reg_rdata,
    output logic [NUM_SRC-1:0]  irq_out
);
    logic [NUM_SRC-1:0] pins;
    logic [NUM_SRC-1:0] synced;
    logic [NUM_SRC-1:0] rise_sel;
    logic [NUM_SRC-1:0] sw_clr;
    logic [NUM_SRC-1:0] levels;
    logic [NUM_SRC-1:0] reqs;
    src_status_t        stat [NUM_SRC];

    assign pins = {pin_vsync, pin_gen};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst        (rst),
            .pin_async  (pins[i]),
            .pin_synced (synced[i])
        );

        edge_unit u_edge (
            .clk      (clk),
            .rst      (rst),
            .lvl_sync (synced[i]),
            .rise_sel (rise_sel[i]),
            .en       (irq_en[i]),
            .ack      (irq_ack[i]),
            .sw_clr   (sw_clr[i]),
            .status   (stat[i])
        );

        assign levels[i]  = stat[i].level;
        assign reqs[i]    = stat[i].req;
        assign irq_out[i] = stat[i].irq;
    end

    edge_reg_if #(.N(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .levels   (levels),
        .reqs     (reqs),
        .rise_sel (rise_sel),
        .sw_clr   (sw_clr),
        .rdata    (reg_rdata)
    );

endmodule

// File: tb/edge_irq_detect_bench.sv
`timescale 1ns/1ps
module edge_irq_detect_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_gen = 1'b0;
    logic       pin_vsync = 1'b1;
    logic [1:0] irq_en = 2'b00;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [1:0] reg_rdata;
    logic [1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    edge_irq_detect u_edge_irq_detect (
        .clk(clk), .rst(rst), .pin_gen(pin_gen), .pin_vsync(pin_vsync),
        .irq_en(irq_en), .irq_ack(irq_ack), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // Reference model built from the requirements
    logic [1:0] m_s1, m_s2, m_prev, m_lev, m_req, m_irq, m_sel;
    logic [1:0] m_pol, m_edge, m_clr, m_nxt, m_swclr;
    wire  [1:0] pins = {pin_vsync, pin_gen};

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= pins; m_s2 <= pins; m_prev <= ~pins; m_lev <= pins;
            m_req <= 2'b00; m_irq <= 2'b00; m_sel <= 2'b00;
        end else begin
            m_swclr = (reg_wr && reg_addr == 2'd2) ? reg_wdata : 2'b00;
            m_pol   = ~(m_s2 ^ m_sel);
            m_edge  = m_pol & ~m_prev;
            m_clr   = m_swclr | (irq_ack & irq_en);
            m_nxt   = m_edge | (m_req & ~m_clr);
            m_s1 <= pins; m_s2 <= m_s1; m_lev <= m_s2;
            m_prev <= m_pol; m_req <= m_nxt; m_irq <= m_nxt & irq_en;
            if (reg_wr && reg_addr == 2'd0) m_sel <= reg_wdata;
        end
    end

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0; reg_wdata = 2'b00;
    endtask

    function automatic logic [1:0] fold(input logic [1:0] lv, input logic [1:0] sel);
        return ~(lv ^ sel);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] v;
        process::self().srandom(32'd1234);
        @(negedge clk);
        step(4);
        rst = 1'b0;
        step(1);
        // R1 reset state
        read_reg(2'd1, v); check(v, 2'b10, "R1 level after reset");
        read_reg(2'd2, v); check(v, 2'b00, "R1 request after reset");
        read_reg(2'd0, v); check(v, 2'b00, "R8 polarity reads zero");
        check(irq_out, 2'b00, "R1 irq after reset");

        // R2 rising edge latency on the general pin
        write_reg(2'd0, 2'b01);
        pin_gen = 1'b1;
        step(2);
        read_reg(2'd2, v); check(v, 2'b00, "R2 not yet set after two edges");
        read_reg(2'd1, v); check(v, 2'b10, "R6 level not yet updated");
        step(1);
        read_reg(2'd2, v); check(v, 2'b01, "R2 set on third edge");
        read_reg(2'd1, v); check(v, 2'b11, "R6 level updated while disabled");

        // R7 sticky while disabled, acknowledge ignored
        irq_ack = 2'b11; step(1); irq_ack = 2'b00; step(2);
        read_reg(2'd2, v); check(v, 2'b01, "R7 ack ignored while disabled");
        check(irq_out, 2'b00, "R10 no irq while disabled");

        // R8 writing zeros leaves flags, writing one clears
        write_reg(2'd2, 2'b10);
        read_reg(2'd2, v); check(v, 2'b01, "R8 zero bit keeps flag");
        write_reg(2'd2, 2'b01);
        read_reg(2'd2, v); check(v, 2'b00, "R8 one bit clears flag");

        // R4 opposite edge ignored
        pin_gen = 1'b0; step(4);
        read_reg(2'd2, v); check(v, 2'b00, "R4 falling ignored when rising selected");
        // R4 vsync rising ignored with falling selected
        pin_vsync = 1'b0; step(4);
        pin_vsync = 1'b1; step(4);
        read_reg(2'd2, v); check(v, 2'b10, "R3 vsync falling sets flag");
        write_reg(2'd2, 2'b10);
        pin_vsync = 1'b0; step(4);
        read_reg(2'd2, v); check(v, 2'b10, "R3 second falling edge sets flag");
        write_reg(2'd2, 2'b10);
        pin_vsync = 1'b1; step(4);
        read_reg(2'd2, v); check(v, 2'b00, "R4 vsync rising ignored");

        // R5 select change with steady high pin
        pin_gen = 1'b1; step(4);
        write_reg(2'd2, 2'b01);
        write_reg(2'd0, 2'b00);
        step(1);
        read_reg(2'd2, v); check(v, 2'b00, "R5 rising to falling with pin high no request");
        write_reg(2'd0, 2'b01);
        read_reg(2'd2, v); check(v, 2'b00, "R5 not set in write cycle");
        step(1);
        read_reg(2'd2, v); check(v, 2'b01, "R5 select change sets flag");

        // R10 enable drives irq one edge later
        irq_en = 2'b01; step(1);
        check(irq_out, 2'b01, "R10 irq follows enable");
        irq_en = 2'b00; step(1);
        check(irq_out, 2'b00, "R10 irq drops with enable");
        irq_en = 2'b01; step(1);

        // R9 acknowledge clears when enabled
        irq_ack = 2'b01; step(1); irq_ack = 2'b00;
        read_reg(2'd2, v); check(v, 2'b00, "R9 ack clears flag");
        check(irq_out, 2'b00, "R9 irq cleared by ack");

        // R9 set beats clear in the same cycle
        write_reg(2'd0, 2'b00);
        pin_gen = 1'b1;
        write_reg(2'd0, 2'b01);
        irq_ack = 2'b01; step(1); irq_ack = 2'b00;
        read_reg(2'd2, v); check(v, 2'b01, "R9 set wins over ack");
        check(irq_out, 2'b01, "R10 irq with set-wins");
        write_reg(2'd2, 2'b11);
        step(1);

        // Random phase against the reference model
        for (int c = 0; c < 3000; c++) begin
            check(irq_out, m_irq, "R10 random irq");
            read_reg(2'd1, v); check(v, m_lev, "R6 random level");
            read_reg(2'd2, v); check(v, m_req, "R2 R3 R7 R9 random request");
            read_reg(2'd0, v); check(v, 2'b00, "R8 random polarity read");
            if ($urandom_range(0, 5) == 0) pin_gen   = ~pin_gen;
            if ($urandom_range(0, 5) == 0) pin_vsync = ~pin_vsync;
            irq_en  = 2'($urandom_range(0, 3));
            irq_ack = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            reg_wr  = ($urandom_range(0, 7) == 0);
            reg_addr  = 2'($urandom_range(0, 2));
            reg_wdata = 2'($urandom_range(0, 3));
            @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b0;
        end
        check(fold(2'b11, 2'b01), 2'b01, "R5 fold helper sanity");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule